// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the pointer that selects the active window of a windowed integer register file. It also holds a bitmask that marks windows as unavailable, and the fields of the processor status word. Commands arrive one per cycle as an operation code with a 32-bit data word. Six operations are defined: move to the previous window (save), move to the next window (restore), return from trap, write the status word, read the status word, and load the invalid-window mask.

The pointer wraps modulo a window count set by a parameter. Every move is checked against the invalid mask before it commits. A move into a marked window does not commit. Instead the block raises a single-cycle trap request that carries a type code. An out-of-range pointer field in a status write gives an illegal-instruction trap and changes no state. The block also gives the base offset of the current window into the register array, so the register file can add a local register index to it.

Top module: `regwin_ctrl`

## Requirements
- R1: A save moves the pointer to pointer-1. From window 0 it moves to window NWIN-1.
- R2: A restore moves the pointer to pointer+1. From window NWIN-1 it moves to window 0.
- R3: A save or restore whose target window has its mask bit set (bit index = target window) leaves the pointer unchanged and raises a trap. A save raises code 8'h05 (overflow) and a restore raises code 8'h06 (underflow).
- R4: A return from trap while the enable-traps bit is 1 raises code 8'h02 and changes nothing. While the bit is 0 and the target is valid, it does three things: it moves the pointer as a restore does, it sets enable-traps to 1, and it copies previous-supervisor into supervisor.
- R5: A status write whose low five bits are NWIN or greater raises code 8'h02 and leaves every field and the pointer unchanged.
- R6: The status word has this layout: [31:24] constant VERSION, [23:20] condition codes, [12] FP enable, [11:8] interrupt level, [7] supervisor, [6] previous supervisor, [5] enable traps, [4:0] pointer. All other bits read 0. A valid write loads every field except the version. A read returns the word on rd_data with rd_valid high for one cycle.
- R7: base_o always equals the pointer times 16.
- R8: After reset the pointer is 0 and the mask is clear. The status word reads VERSION<<24 | 8'h80, which means supervisor is 1 and every other field is 0. trap_req and rd_valid are 0.
- R9: The load-mask operation (op 6) replaces the whole 32-bit mask with cmd_data.
- R10: trap_req is high for exactly the one cycle after a command that traps, and at most one code is given per command. Commands that do not trap leave it low.
- R11: A return from trap that hits a masked target raises code 8'h06. It leaves the pointer, enable-traps and supervisor unchanged.

Command codes on cmd_op: 0 none, 1 save, 2 restore, 3 return from trap, 4 status write, 5 status read, 6 load mask. Each command takes effect at the clock edge where cmd_valid is sampled high. Its trap and read results are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 32 | Status word or mask for write commands |
| cwp_o | output | 5 | Current window pointer |
| base_o | output | 9 | Register file offset of the current window |
| rd_valid | output | 1 | Status read data valid |
| rd_data | output | 32 | Packed status word |
| trap_req | output | 1 | Trap request pulse |
| trap_code | output | 8 | Trap type carried with trap_req |

## Verification
The checker watches several behaviours on every cycle:
- the pointer stays below NWIN;
- the two wrap transitions happen at the edges of the window range;
- a trap never coexists with a pointer change;
- the trap codes for return-while-enabled and for an oversize pointer field are correct.

Other behaviours can only be shown by the bench's scenarios:
- the packing of the status word;
- the fact that a rejected write or return leaves the other fields untouched;
- the exact pointer reached from every start window under clear and blocking masks.

The bench sweeps all start windows and all 32 pointer-field values on a six-window instance.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   localparam int CWP_W  = 5;
   localparam int WORD_W = 32;

   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_SAVE    = 3'd1,
      OP_RESTORE = 3'd2,
      OP_RETT    = 3'd3,
      OP_WRSTAT  = 3'd4,
      OP_RDSTAT  = 3'd5,
      OP_WRMASK  = 3'd6
   } op_e;

   localparam logic [7:0] TRAP_ILLEGAL = 8'h02;
   localparam logic [7:0] TRAP_WIN_OVF = 8'h05;
   localparam logic [7:0] TRAP_WIN_UNF = 8'h06;

   typedef struct packed {
      logic [3:0] icc;
      logic       fp_en;
      logic [3:0] irq_lvl;
      logic       sup;
      logic       prev_sup;
      logic       trap_en;
   } stat_t;
endpackage

// File: rtl/regwin_step.sv
module regwin_step #(
   parameter int NWIN = 8
) (
   input  logic [regwin_pkg::CWP_W-1:0] cur,
   output logic [regwin_pkg::CWP_W-1:0] nxt_up,
   output logic [regwin_pkg::CWP_W-1:0] nxt_dn
);
   import regwin_pkg::*;
   localparam int  LW      = (NWIN > 1) ? $clog2(NWIN) : 1;
   localparam bit  IS_POW2 = (NWIN == (1 << LW));

   generate
      if (IS_POW2) begin : g_pow2
         logic [LW-1:0] up_t, dn_t;
         always_comb begin
            up_t   = cur[LW-1:0] + 1'b1;
            dn_t   = cur[LW-1:0] - 1'b1;
            nxt_up = CWP_W'(up_t);
            nxt_dn = CWP_W'(dn_t);
         end
      end else begin : g_cmp
         always_comb begin
            nxt_up = (cur == CWP_W'(NWIN - 1)) ? '0 : cur + 1'b1;
            nxt_dn = (cur == '0) ? CWP_W'(NWIN - 1) : cur - 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/regwin_stat.sv
module regwin_stat #(
   parameter logic [7:0] VERSION = 8'h00
) (
   input  regwin_pkg::stat_t                fld,
   input  logic [regwin_pkg::CWP_W-1:0]     cwp,
   input  logic [regwin_pkg::WORD_W-1:0]    word_in,
   output logic [regwin_pkg::WORD_W-1:0]    word_out,
   output regwin_pkg::stat_t                fld_in
);
   import regwin_pkg::*;
   always_comb begin
      word_out        = '0;
      word_out[31:24] = VERSION;
      word_out[23:20] = fld.icc;
      word_out[12]    = fld.fp_en;
      word_out[11:8]  = fld.irq_lvl;
      word_out[7]     = fld.sup;
      word_out[6]     = fld.prev_sup;
      word_out[5]     = fld.trap_en;
      word_out[4:0]   = cwp;

      fld_in.icc      = word_in[23:20];
      fld_in.fp_en    = word_in[12];
      fld_in.irq_lvl  = word_in[11:8];
      fld_in.sup      = word_in[7];
      fld_in.prev_sup = word_in[6];
      fld_in.trap_en  = word_in[5];
   end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
   parameter int         NWIN    = 8,
   parameter logic [7:0] VERSION = 8'hA5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [2:0]  cmd_op,
   input  logic [31:0] cmd_data,
   output logic [4:0]  cwp_o,
   output logic [8:0]  base_o,
   output logic        rd_valid,
   output logic [31:0] rd_data,
   output logic        trap_req,
   output logic [7:0]  trap_code
);
   import regwin_pkg::*;
   localparam int BASE_SH = 4;

   generate
      if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
         $error("regwin_ctrl: NWIN must lie in 2..32");
      end
   endgenerate

   logic [CWP_W-1:0]  cwp_q, up_w, dn_w;
   logic [WORD_W-1:0] mask_q, packed_w;
   stat_t             st_q, st_in_w;
   logic              cwp_field_bad;
   op_e               op_w;

   regwin_step #(.NWIN(NWIN)) u_step (
      .cur(cwp_q), .nxt_up(up_w), .nxt_dn(dn_w)
   );

   regwin_stat #(.VERSION(VERSION)) u_stat (
      .fld(st_q), .cwp(cwp_q), .word_in(cmd_data),
      .word_out(packed_w), .fld_in(st_in_w)
   );

   assign op_w          = op_e'(cmd_op);
   assign cwp_field_bad = ({1'b0, cmd_data[CWP_W-1:0]} >= (CWP_W+1)'(NWIN));
   assign cwp_o         = cwp_q;
   assign base_o        = {cwp_q, {BASE_SH{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwp_q     <= '0;
         mask_q    <= '0;
         st_q      <= '{icc: 4'h0, fp_en: 1'b0, irq_lvl: 4'h0,
                        sup: 1'b1, prev_sup: 1'b0, trap_en: 1'b0};
         trap_req  <= 1'b0;
         trap_code <= '0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
      end else begin
         trap_req <= 1'b0;
         rd_valid <= 1'b0;
         if (cmd_valid) begin
            case (op_w)
               OP_SAVE: begin
                  if (mask_q[dn_w]) begin
                     trap_req  <= 1'b1;
                     trap_code <= TRAP_WIN_OVF;
                  end else begin
                     cwp_q <= dn_w;
                  end
               end
               OP_RESTORE: begin
                  if (mask_q[up_w]) begin
                     trap_req  <= 1'b1;
                     trap_code <= TRAP_WIN_UNF;
                  end else begin
                     cwp_q <= up_w;
                  end
               end
               OP_RETT: begin
                  if (st_q.trap_en) begin
                     trap_req  <= 1'b1;
                     trap_code <= TRAP_ILLEGAL;
                  end else if (mask_q[up_w]) begin
                     trap_req  <= 1'b1;
                     trap_code <= TRAP_WIN_UNF;
                  end else begin
                     cwp_q       <= up_w;
                     st_q.trap_en <= 1'b1;
                     st_q.sup     <= st_q.prev_sup;
                  end
               end
               OP_WRSTAT: begin
                  if (cwp_field_bad) begin
                     trap_req  <= 1'b1;
                     trap_code <= TRAP_ILLEGAL;
                  end else begin
                     st_q  <= st_in_w;
                     cwp_q <= cmd_data[CWP_W-1:0];
                  end
               end
               OP_RDSTAT: begin
                  rd_valid <= 1'b1;
                  rd_data  <= packed_w;
               end
               OP_WRMASK: mask_q <= cmd_data;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/regwin_ctrl_chk.sv
module regwin_ctrl_chk #(
   parameter int NWIN = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic [2:0]  cmd_op,
   input logic [31:0] cmd_data,
   input logic [4:0]  cwp_o,
   input logic        trap_req,
   input logic [7:0]  trap_code,
   input logic [31:0] mask_q,
   input logic        et_bit
);
   localparam logic [4:0] LAST = 5'(NWIN - 1);

   AST_CWP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, cwp_o} < 6'(NWIN));                                              // R1

   AST_SAVE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd1 && cwp_o == 5'd0 && !mask_q[LAST])
      |=> (cwp_o == LAST));                                                   // R1

   AST_RESTORE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd2 && cwp_o == LAST && !mask_q[0])
      |=> (cwp_o == 5'd0));                                                   // R2

   AST_TRAP_HOLDS_CWP: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (cwp_o == $past(cwp_o)));                                  // R3

   AST_RETT_ENABLED_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd3 && et_bit)
      |=> (trap_req && trap_code == 8'h02));                                  // R4

   AST_WRSTAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd4 && ({1'b0, cmd_data[4:0]} >= 6'(NWIN)))
      |=> (trap_req && trap_code == 8'h02));                                  // R5

   AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(cmd_valid));                                         // R10
endmodule

bind regwin_ctrl regwin_ctrl_chk #(.NWIN(NWIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_data(cmd_data), .cwp_o(cwp_o), .trap_req(trap_req),
   .trap_code(trap_code), .mask_q(mask_q), .et_bit(st_q.trap_en)
);

// File: tb/regwin_ctrl_tb.sv
`timescale 1ns/1ps
module regwin_ctrl_tb;
   localparam int         NW  = 6;
   localparam logic [7:0] VER = 8'hA5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [31:0] cmd_data = '0;
   logic [4:0]  cwp_o;
   logic [8:0]  base_o;
   logic        rd_valid, trap_req;
   logic [31:0] rd_data;
   logic [7:0]  trap_code;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   regwin_ctrl #(.NWIN(NW), .VERSION(VER)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .cwp_o(cwp_o), .base_o(base_o),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .trap_req(trap_req), .trap_code(trap_code)
   );

   // bench model of the architectural state
   int m_cwp, m_icc, m_ef, m_pil, m_s, m_ps, m_et;

   function automatic logic [31:0] pack_model();
      return (32'(VER) << 24) | (32'(m_icc) << 20) | (32'(m_ef) << 12) |
             (32'(m_pil) << 8) | (32'(m_s) << 7) | (32'(m_ps) << 6) |
             (32'(m_et) << 5) | 32'(m_cwp);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [2:0] op, input logic [31:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
   endtask

   task automatic wr_stat(input int c, input int icc, input int ef, input int pil,
                          input int s, input int ps, input int et);
      m_cwp = c; m_icc = icc; m_ef = ef; m_pil = pil; m_s = s; m_ps = ps; m_et = et;
      cmd(3'd4, pack_model());
   endtask

   task automatic rd_check(input string req);
      cmd(3'd5, 32'd0);
      chk({req, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
      chk({req, " status"}, rd_data, pack_model());
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      m_cwp = 0; m_icc = 0; m_ef = 0; m_pil = 0; m_s = 1; m_ps = 0; m_et = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8 cwp", 32'(cwp_o), 32'd0);
      chk("R8 trap", {31'd0, trap_req}, 32'd0);
      chk("R8 rd_valid", {31'd0, rd_valid}, 32'd0);
      rd_check("R8");
      chk("R8 word", rd_data, 32'hA500_0080);
      @(negedge clk);
      chk("R6 rd_valid one cycle", {31'd0, rd_valid}, 32'd0);

      // R1 R2 R7 sweep with clear mask
      cmd(3'd6, 32'd0);
      for (int st = 0; st < NW; st++) begin
         wr_stat(st, 0, 0, 0, 1, 0, 0);
         chk("R7 base after write", 32'(base_o), 32'(st * 16));
         cmd(3'd1, 32'd0);
         chk("R1 save cwp", 32'(cwp_o), 32'((st + NW - 1) % NW));
         chk("R7 base", 32'(base_o), 32'(((st + NW - 1) % NW) * 16));
         chk("R10 no trap on save", {31'd0, trap_req}, 32'd0);
         cmd(3'd2, 32'd0);
         cmd(3'd2, 32'd0);
         chk("R2 restore cwp", 32'(cwp_o), 32'((st + 1) % NW));
      end

      // R3 R9 blocked moves, every start window
      for (int st = 0; st < NW; st++) begin
         wr_stat(st, 0, 0, 0, 1, 0, 0);
         cmd(3'd6, 32'd1 << ((st + NW - 1) % NW));
         cmd(3'd1, 32'd0);
         chk("R3 save trap", {31'd0, trap_req}, 32'd1);
         chk("R3 save code", 32'(trap_code), 32'h05);
         chk("R3 save hold", 32'(cwp_o), 32'(st));
         @(negedge clk);
         chk("R10 pulse ends", {31'd0, trap_req}, 32'd0);
         cmd(3'd2, 32'd0);
         chk("R9 other bit free", 32'(cwp_o), 32'((st + 1) % NW));
         cmd(3'd1, 32'd0);
         cmd(3'd6, 32'd1 << ((st + 1) % NW));
         cmd(3'd2, 32'd0);
         chk("R3 restore trap", {31'd0, trap_req}, 32'd1);
         chk("R3 restore code", 32'(trap_code), 32'h06);
         chk("R3 restore hold", 32'(cwp_o), 32'(st));
      end
      cmd(3'd6, 32'd0);

      // R5 R6 status write sweep over every pointer field value
      wr_stat(2, 4'h9, 1, 4'hC, 0, 1, 1);
      for (int c = 0; c < 32; c++) begin
         logic [31:0] w;
         w = (32'h3 << 20) | (32'd0 << 12) | (32'd5 << 8) | (32'd1 << 7) |
             (32'd0 << 6) | (32'd0 << 5) | 32'(c) | 32'hFF00_E000;
         cmd(3'd4, w);
         if (c >= NW) begin
            chk("R5 illegal trap", {31'd0, trap_req}, 32'd1);
            chk("R5 illegal code", 32'(trap_code), 32'h02);
         end else begin
            chk("R10 legal no trap", {31'd0, trap_req}, 32'd0);
            m_cwp = c; m_icc = 3; m_ef = 0; m_pil = 5; m_s = 1; m_ps = 0; m_et = 0;
         end
         rd_check(c >= NW ? "R5 unchanged" : "R6 packed");
         if (c == NW - 1) wr_stat(2, 4'h9, 1, 4'hC, 0, 1, 1);
      end

      // R4 return from trap
      wr_stat(3, 0, 0, 0, 0, 1, 1);
      cmd(3'd3, 32'd0);
      chk("R4 enabled illegal", {31'd0, trap_req}, 32'd1);
      chk("R4 code", 32'(trap_code), 32'h02);
      rd_check("R4 no change");
      wr_stat(NW - 1, 0, 0, 0, 0, 1, 0);
      cmd(3'd3, 32'd0);
      chk("R4 no trap", {31'd0, trap_req}, 32'd0);
      m_cwp = 0; m_et = 1; m_s = 1;
      rd_check("R4 rett fields");
      wr_stat(1, 0, 0, 0, 1, 0, 0);
      cmd(3'd3, 32'd0);
      m_cwp = 2; m_et = 1; m_s = 0;
      rd_check("R4 rett copies ps");

      // R11 rett into masked window
      wr_stat(4, 0, 0, 0, 0, 1, 0);
      cmd(3'd6, 32'd1 << 5);
      cmd(3'd3, 32'd0);
      chk("R11 trap", {31'd0, trap_req}, 32'd1);
      chk("R11 code", 32'(trap_code), 32'h06);
      rd_check("R11 unchanged");

      // R9 full mask replace: mask only window 5 cleared next
      cmd(3'd6, 32'hFFFF_FFDF);
      cmd(3'd2, 32'd0);
      chk("R9 replaced mask", 32'(cwp_o), 32'd5);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule